// File: doc/BRIEF.md
# Two-Wire Register Access Slave with Commit-on-STOP Writes

This block is a two-wire serial (I2C-compatible) slave that lets an external host read and write a byte-wide register file through a 16-bit register offset. It filters and synchronises the serial clock and data lines and detects START and STOP conditions. It shifts bytes in and out and drives the acknowledge bit. Toward the register file it has a combinational read port and a wide write port that is strobed once per committed block.

A write transaction carries the device address with the write bit, then the offset high byte, then the offset low byte, then data bytes. Data bytes are collected in a staging buffer and are not applied while the transfer runs. When STOP arrives, the whole block is presented on the write port in one cycle. A repeated START throws the staged bytes away. Reads start either with a write-mode offset phase followed by a repeated START (random read), or directly with the read-mode address (current-address read). An internal pointer advances after every byte and is kept across transactions.

The FSM states are `ST_IDLE`, `ST_DEV_ADDR`, `ST_DEV_ACK`, `ST_RX_BYTE`, `ST_RX_ACK`, `ST_TX_BYTE`, `ST_TX_ACK` and `ST_WAIT`. These transitions apply in every state:
- STOP goes to `ST_IDLE`.
- START goes to `ST_DEV_ADDR`.

The remaining transitions are:
- `ST_DEV_ADDR` goes to `ST_DEV_ACK` on the eighth-bit SCL fall when the address matches and busy is low, and to `ST_WAIT` otherwise.
- `ST_DEV_ACK` goes to `ST_TX_BYTE` (read) or `ST_RX_BYTE` (write) on the SCL fall.
- `ST_RX_BYTE` goes to `ST_RX_ACK` after eight bits.
- `ST_RX_ACK` goes back to `ST_RX_BYTE` if the byte was acknowledged, and to `ST_WAIT` if not.
- `ST_TX_BYTE` goes to `ST_TX_ACK` after eight bits.
- `ST_TX_ACK` goes to `ST_TX_BYTE` on a master ACK and to `ST_WAIT` on a NACK.

Top module: `i2c_staged_regslave`

## Requirements
- R1: After reset, the slave does not pull SDA and does not strobe the write port.
- R2: The slave acknowledges a device address byte only when its upper seven bits equal {cfg_dev_hi, addr_strap}. Bit 0 of that byte is the direction: 1 means read. Any other address is not acknowledged.
- R3: While busy is high, the slave does not acknowledge its own address.
- R4: In a write, the two bytes after the address form the offset, high byte first. Data bytes target ascending offsets starting there, and every byte is shifted MSB first.
- R5: Staged bytes do not reach the write port before STOP. At STOP, rf_wr_en pulses high for exactly one cycle. In that cycle rf_wr_addr holds the block's first offset, rf_wr_len holds the byte count, and byte k of the block sits in rf_wr_data[8k+7:8k].
- R6: A write block ended by a repeated START instead of STOP is discarded, and no write strobe is produced.
- R7: The staging buffer holds STAGE_DEPTH (16) bytes. A further data byte is not acknowledged, and the first 16 bytes are still committed at STOP.
- R8: A random read returns the registers from the given offset upward, MSB first.
- R9: The pointer advances by one per accepted or transmitted byte and survives STOP. A current-address read returns data from that pointer.
- R10: A master NACK ends a read. The slave releases SDA, and SDA is pulled only in acknowledge slots and slave-transmit bits.
- R11: Pulses on SCL that are shorter than FILT_LEN clock cycles are ignored.
- R12: The slave works with SCL periods of 80 and 320 system clock cycles. These correspond to 400 kHz and 100 kHz at a 32 MHz system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain drive) |
| cfg_dev_hi | input | 6 | Upper six bits of the 7-bit device address, from a configuration register |
| addr_strap | input | 1 | Strap pin supplying the device address LSB |
| busy | input | 1 | While high, the own address is not acknowledged |
| rf_rd_addr | output | 16 | Register file read offset (the pointer) |
| rf_rd_data | input | 8 | Register file read data, combinational from rf_rd_addr |
| rf_wr_en | output | 1 | One-cycle commit strobe |
| rf_wr_addr | output | 16 | First offset of the committed block |
| rf_wr_len | output | 5 | Number of bytes in the committed block |
| rf_wr_data | output | 128 | Staged bytes, byte k in bits [8k+7:8k] |

## Verification
A STOP condition makes the slave clear the staging buffer and publish the commit in the same cycle. A wrong design could therefore publish a zero length or lose the last byte. The bench provokes this with a 17-byte write that fills the buffer and is NACKed at the end, followed at once by STOP. It judges the result from the exact count of write strobes and the register contents from the offset through one beyond the sixteenth byte. A second case closes an unfinished write with a repeated START that leads straight into a current-address read. There, the bench checks that no strobe appears and that the read starts at the pointer advanced by the discarded bytes.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int OFF_W  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV_ADDR,
        ST_DEV_ACK,
        ST_RX_BYTE,
        ST_RX_ACK,
        ST_TX_BYTE,
        ST_TX_ACK,
        ST_WAIT
    } slv_state_t;

    typedef enum logic [1:0] {
        PH_OFF_HI,
        PH_OFF_LO,
        PH_DATA
    } rx_phase_t;

endpackage

// File: rtl/i2cs_glitch_filter.sv
module i2cs_glitch_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], din};
            if (sync_q[1] == dout) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                dout  <= sync_q[1];
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R11
    glitch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> ($past(sync_q[1]) == dout) && ($past(sync_q[1], 2) == dout));

endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    assign scl_rise  =  scl_f & ~scl_p;
    assign scl_fall  = ~scl_f &  scl_p;
    assign start_evt =  scl_f &  scl_p &  sda_p & ~sda_f;
    assign stop_evt  =  scl_f &  scl_p & ~sda_p &  sda_f;

endmodule

// File: rtl/i2cs_stage_buf.sv
module i2cs_stage_buf #(
    parameter int DEPTH = 16,
    parameter int BW    = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                push,
    input  logic [BW-1:0]       push_data,
    output logic [CNT_W-1:0]    count,
    output logic                full,
    output logic [DEPTH*BW-1:0] flat_data
);
    assign full = (count == CNT_W'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          count <= '0;
        else if (clear)      count <= '0;
        else if (push)       count <= count + 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flat_data[g*BW +: BW] <= '0;
            else if (push && !clear && count == CNT_W'(g))
                flat_data[g*BW +: BW] <= push_data;
        end
    end

    // R7
    stage_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R7
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

endmodule

// File: rtl/i2c_staged_regslave.sv
module i2c_staged_regslave
    import i2cs_pkg::*;
#(
    parameter int STAGE_DEPTH = 16,
    parameter int FILT_LEN    = 4,
    localparam int CNT_W      = $clog2(STAGE_DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scl_i,
    input  logic                          sda_i,
    output logic                          sda_pull,
    input  logic [5:0]                    cfg_dev_hi,
    input  logic                          addr_strap,
    input  logic                          busy,
    output logic [OFF_W-1:0]              rf_rd_addr,
    input  logic [BYTE_W-1:0]             rf_rd_data,
    output logic                          rf_wr_en,
    output logic [OFF_W-1:0]              rf_wr_addr,
    output logic [CNT_W-1:0]              rf_wr_len,
    output logic [STAGE_DEPTH*BYTE_W-1:0] rf_wr_data
);
    // line conditioning
    logic [1:0] raw_lines, filt_lines;
    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        i2cs_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (filt_lines[g])
        );
    end

    logic scl_f, sda_f;
    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    logic scl_rise, scl_fall, start_evt, stop_evt;

    i2cs_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    // protocol state
    slv_state_t         state, state_nx;
    rx_phase_t          phase;
    logic [3:0]         bitcnt;
    logic [BYTE_W-1:0]  shreg, txreg, off_hi;
    logic [OFF_W-1:0]   ptr, base;
    logic               ack_q, m_ack, is_read;

    logic               buf_full, buf_push, buf_clear;
    logic [CNT_W-1:0]   buf_count;

    logic byte_end, addr_hit, data_ok;
    assign byte_end = scl_fall && (bitcnt == 4'd8);
    assign addr_hit = (shreg[7:1] == {cfg_dev_hi, addr_strap}) && !busy;
    assign data_ok  = (phase != PH_DATA) || !buf_full;
    assign buf_push = (state == ST_RX_BYTE) && byte_end && (phase == PH_DATA)
                      && !buf_full && !start_evt && !stop_evt;
    assign buf_clear = start_evt || stop_evt;
    assign rf_rd_addr = ptr;

    i2cs_stage_buf #(.DEPTH(STAGE_DEPTH), .BW(BYTE_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (buf_clear),
        .push     (buf_push),
        .push_data(shreg),
        .count    (buf_count),
        .full     (buf_full),
        .flat_data(rf_wr_data)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        if (stop_evt) begin
            state_nx = ST_IDLE;
        end else if (start_evt) begin
            state_nx = ST_DEV_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_DEV_ADDR: if (byte_end) state_nx = addr_hit ? ST_DEV_ACK : ST_WAIT;
                ST_DEV_ACK:  if (scl_fall) state_nx = is_read ? ST_TX_BYTE : ST_RX_BYTE;
                ST_RX_BYTE:  if (byte_end) state_nx = ST_RX_ACK;
                ST_RX_ACK:   if (scl_fall) state_nx = ack_q ? ST_RX_BYTE : ST_WAIT;
                ST_TX_BYTE:  if (byte_end) state_nx = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) state_nx = m_ack ? ST_TX_BYTE : ST_WAIT;
                ST_WAIT:     state_nx = ST_WAIT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull   <= 1'b0;
            rf_wr_en   <= 1'b0;
            rf_wr_addr <= '0;
            rf_wr_len  <= '0;
            phase      <= PH_OFF_HI;
            bitcnt     <= '0;
            shreg      <= '0;
            txreg      <= '0;
            off_hi     <= '0;
            ptr        <= '0;
            base       <= '0;
            ack_q      <= 1'b0;
            m_ack      <= 1'b0;
            is_read    <= 1'b0;
        end else begin
            rf_wr_en <= 1'b0;
            if (stop_evt) begin
                sda_pull   <= 1'b0;
                rf_wr_en   <= (buf_count != '0);
                rf_wr_addr <= base;
                rf_wr_len  <= buf_count;
            end else if (start_evt) begin
                sda_pull <= 1'b0;
                bitcnt   <= '0;
            end else begin
                unique case (state)
                    ST_DEV_ADDR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_f};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_end) begin
                            bitcnt <= '0;
                            if (addr_hit) begin
                                sda_pull <= 1'b1;
                                is_read  <= shreg[0];
                                phase    <= PH_OFF_HI;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall) begin
                            if (is_read) begin
                                txreg    <= rf_rd_data;
                                sda_pull <= ~rf_rd_data[7];
                                ptr      <= ptr + 16'd1;
                            end else begin
                                sda_pull <= 1'b0;
                            end
                        end
                    end
                    ST_RX_BYTE: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_f};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_end) begin
                            bitcnt   <= '0;
                            sda_pull <= data_ok;
                            ack_q    <= data_ok;
                            unique case (phase)
                                PH_OFF_HI: begin
                                    off_hi <= shreg;
                                    phase  <= PH_OFF_LO;
                                end
                                PH_OFF_LO: begin
                                    ptr   <= {off_hi, shreg};
                                    base  <= {off_hi, shreg};
                                    phase <= PH_DATA;
                                end
                                default: begin
                                    if (!buf_full) ptr <= ptr + 16'd1;
                                end
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) sda_pull <= 1'b0;
                    end
                    ST_TX_BYTE: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_pull <= 1'b0;
                                bitcnt   <= '0;
                            end else begin
                                txreg    <= {txreg[6:0], 1'b0};
                                sda_pull <= ~txreg[6];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_f;
                        end else if (scl_fall && m_ack) begin
                            txreg    <= rf_rd_data;
                            sda_pull <= ~rf_rd_data[7];
                            ptr      <= ptr + 16'd1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5
    commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> $past(stop_evt));

    // R5
    commit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> (rf_wr_len != '0) && (rf_wr_len <= CNT_W'(STAGE_DEPTH)));

    // R3
    busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK && $past(state) == ST_DEV_ADDR) |-> !$past(busy));

    // R10
    wait_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !sda_pull);

endmodule

// File: tb/i2c_staged_regslave_tb.sv
module i2c_staged_regslave_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic         m_scl = 1'b1, m_sda = 1'b1;
    logic         sda_pull;
    logic [5:0]   cfg_dev_hi = 6'b010110;
    logic         addr_strap = 1'b0;
    logic         busy = 1'b0;
    logic [15:0]  rf_rd_addr;
    logic [7:0]   rf_rd_data;
    logic         rf_wr_en;
    logic [15:0]  rf_wr_addr;
    logic [4:0]   rf_wr_len;
    logic [127:0] rf_wr_data;

    wire sda_line = m_sda & ~sda_pull;

    i2c_staged_regslave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_pull(sda_pull), .cfg_dev_hi(cfg_dev_hi), .addr_strap(addr_strap),
        .busy(busy), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_len(rf_wr_len),
        .rf_wr_data(rf_wr_data)
    );

    // bench register file, fed by the write port
    logic [7:0] mem [0:255];
    logic [7:0] exp_mem [0:255];
    assign rf_rd_data = mem[rf_rd_addr[7:0]];

    int  total = 0, bad = 0;
    int  drive_viol = 0, commit_viol = 0, commit_seen = 0;
    bit  may_drive = 0, prev_slot = 0, commit_win = 0, glitch_on = 0;
    int  q = 20;
    logic [15:0] exp_ptr = 16'h0000;
    logic [7:0]  wbuf [0:16];
    logic [7:0]  rbuf [0:7];
    bit          acks [0:19];

    // per-clock reference comparison
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        end else begin
            if (sda_pull && !may_drive) drive_viol++;
            if (rf_wr_en) begin
                commit_seen++;
                if (!commit_win) commit_viol++;
                for (int i = 0; i < 16; i++)
                    if (i < int'(rf_wr_len))
                        mem[8'(rf_wr_addr[7:0] + 8'(i))] = rf_wr_data[i*8 +: 8];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic slot(input logic b, input bit slave, output logic smp);
        may_drive = prev_slot | slave;
        tick(q);
        may_drive = slave;
        m_sda = slave ? 1'b1 : b;
        tick(q);
        m_scl = 1'b1;
        tick(q / 2);
        if (glitch_on) begin
            m_scl = 1'b0; tick(1); m_scl = 1'b1;
        end
        tick(q / 2);
        smp = sda_line;
        tick(q);
        m_scl = 1'b0;
        prev_slot = slave;
    endtask

    task automatic i2c_start();
        may_drive = prev_slot;
        m_sda = 1'b1;
        tick(q);
        may_drive = 1'b0;
        m_scl = 1'b1;
        tick(q);
        m_sda = 1'b0;
        tick(q);
        m_scl = 1'b0;
        prev_slot = 1'b0;
    endtask

    task automatic i2c_stop();
        may_drive = prev_slot;
        m_sda = 1'b0;
        tick(q);
        may_drive = 1'b0;
        m_scl = 1'b1;
        tick(q);
        commit_win = 1'b1;
        m_sda = 1'b1;
        tick(2 * q);
        commit_win = 1'b0;
        prev_slot = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] d, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) slot(d[i], 1'b0, s);
        slot(1'b1, 1'b1, s);
        ack = (s == 1'b0);
    endtask

    task automatic rbyte(output logic [7:0] d, input bit mack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            slot(1'b1, 1'b1, s);
            d[i] = s;
        end
        slot(mack ? 1'b0 : 1'b1, 1'b0, s);
    endtask

    function automatic logic [7:0] dev_byte(input bit rd);
        return {cfg_dev_hi, addr_strap, rd};
    endfunction

    // address, offset, n data bytes; acks[0..n+2]; optional STOP
    task automatic wr_block(input logic [15:0] off, input int n, input bit do_stop);
        bit a;
        i2c_start();
        wbyte(dev_byte(1'b0), a); acks[0] = a;
        wbyte(off[15:8], a);      acks[1] = a;
        wbyte(off[7:0], a);       acks[2] = a;
        exp_ptr = off;
        for (int i = 0; i < n; i++) begin
            wbyte(wbuf[i], a);
            acks[3 + i] = a;
            if (a) begin
                if (do_stop) exp_mem[8'(off[7:0] + 8'(i))] = wbuf[i];
                exp_ptr = exp_ptr + 16'd1;
            end
        end
        if (do_stop) i2c_stop();
    endtask

    task automatic rd_block(input bit random, input logic [15:0] off, input int n);
        bit a;
        if (random) begin
            i2c_start();
            wbyte(dev_byte(1'b0), a); acks[0] = a;
            wbyte(off[15:8], a);
            wbyte(off[7:0], a);
            exp_ptr = off;
        end
        i2c_start();
        wbyte(dev_byte(1'b1), a); acks[1] = a;
        for (int i = 0; i < n; i++) rbyte(rbuf[i], (i != n - 1));
        i2c_stop();
    endtask

    int c0;
    logic [15:0] p0;

    initial begin : main
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(20);
        chk("R1 sda released after reset", 32'(sda_pull), 0);
        chk("R1 no write strobe after reset", 32'(commit_seen), 0);

        // R4 / R5: four-byte write at 0x0010
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
        c0 = commit_seen;
        wr_block(16'h0010, 4, 1'b0);
        chk("R2 own address acked", 32'(acks[0]), 1);
        chk("R4 data bytes acked", 32'({acks[3], acks[4], acks[5], acks[6]}), 32'hF);
        chk("R5 register untouched before STOP", 32'(mem[8'h10]), 0);
        chk("R5 no strobe before STOP", 32'(commit_seen - c0), 0);
        i2c_stop();
        for (int i = 0; i < 4; i++) exp_mem[8'h10 + i] = wbuf[i];
        chk("R5 exactly one strobe at STOP", 32'(commit_seen - c0), 1);
        for (int i = 0; i < 4; i++)
            chk("R4 committed byte", 32'(mem[8'h10 + i]), 32'(exp_mem[8'h10 + i]));

        // R8: random read of three bytes
        rd_block(1'b1, 16'h0010, 3);
        for (int i = 0; i < 3; i++)
            chk("R8 random read byte", 32'(rbuf[i]), 32'(exp_mem[8'h10 + i]));
        exp_ptr = 16'h0013;
        tick(q);
        chk("R10 SDA released after master NACK", 32'(sda_pull), 0);

        // R9: current-address read continues at 0x0013
        rd_block(1'b0, 16'h0000, 1);
        chk("R9 current-address read", 32'(rbuf[0]), 32'(exp_mem[8'h13]));

        // R6: write ended by repeated START, then current read
        wbuf[0] = 8'h55; wbuf[1] = 8'h66;
        c0 = commit_seen;
        wr_block(16'h000E, 2, 1'b0);
        rd_block(1'b0, 16'h0000, 1);
        chk("R6 no strobe for discarded block", 32'(commit_seen - c0), 0);
        chk("R6 register 0x0E untouched", 32'(mem[8'h0E]), 0);
        chk("R6 register 0x0F untouched", 32'(mem[8'h0F]), 0);
        chk("R9 pointer advanced past discarded bytes", 32'(rbuf[0]), 32'(exp_mem[8'h10]));

        // R2: strap changes the address LSB
        addr_strap = 1'b1;
        begin
            bit a;
            i2c_start();
            wbyte({6'b010110, 1'b0, 1'b0}, a);
            i2c_stop();
            chk("R2 stale address not acked", 32'(a), 0);
        end
        wbuf[0] = 8'h3C;
        wr_block(16'h0030, 1, 1'b1);
        chk("R2 strapped address acked", 32'(acks[0]), 1);
        chk("R4 byte under strapped address", 32'(mem[8'h30]), 32'h3C);

        // R3: busy blocks the acknowledge
        busy = 1'b1;
        begin
            bit a;
            i2c_start();
            wbyte(dev_byte(1'b0), a);
            i2c_stop();
            chk("R3 no ack while busy", 32'(a), 0);
        end
        busy = 1'b0;

        // R7: seventeen bytes, the last refused
        for (int i = 0; i < 17; i++) wbuf[i] = 8'(8'h80 + i);
        c0 = commit_seen;
        wr_block(16'h0040, 17, 1'b1);
        chk("R7 sixteenth byte acked", 32'(acks[18]), 1);
        chk("R7 seventeenth byte refused", 32'(acks[19]), 0);
        chk("R7 one strobe for full buffer", 32'(commit_seen - c0), 1);
        for (int i = 0; i < 17; i++)
            chk("R7 committed range", 32'(mem[8'h40 + i]), 32'(exp_mem[8'h40 + i]));
        p0 = exp_ptr;
        rd_block(1'b0, 16'h0000, 1);
        chk("R9 pointer after full block", 32'(rbuf[0]), 32'(exp_mem[p0[7:0]]));

        // R12: slow SCL
        q = 80;
        wbuf[0] = 8'h5A; wbuf[1] = 8'hE7;
        wr_block(16'h0080, 2, 1'b1);
        rd_block(1'b1, 16'h0080, 2);
        chk("R12 slow rate byte 0", 32'(rbuf[0]), 32'h5A);
        chk("R12 slow rate byte 1", 32'(rbuf[1]), 32'hE7);
        q = 20;

        // R11: SCL glitches during the high phase
        glitch_on = 1'b1;
        wbuf[0] = 8'h96;
        wr_block(16'h0090, 1, 1'b1);
        rd_block(1'b1, 16'h0090, 1);
        glitch_on = 1'b0;
        chk("R11 glitched write/read", 32'(rbuf[0]), 32'h96);

        chk("R10 SDA pulled only in slave slots", 32'(drive_viol), 0);
        chk("R5 strobes only after STOP", 32'(commit_viol), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule